// File: doc/BRIEF.md
# Sized Add/Subtract Flag Unit

This unit performs the add and subtract step of a 32-bit register-based processor. It handles two kinds of operation. Data operations work on a byte, word or long slice of the operands and produce five condition flags. Address operations always work on the whole 32-bit register, and in their word form the 16-bit source is first sign-extended. The caller presents an operation code, a source value and the current destination register value, then raises a write enable. On the next rising clock edge the updated destination value and the flags are registered together.

When a data operation is narrower than the register, only the low slice of the destination changes. The upper bits of the incoming destination value pass through unchanged. The extend flag always takes the same value as carry after a data operation. Address operations and unrecognised codes never change a flag. When the write enable is low, nothing changes at all.

The 4-bit operation code is split into fields. Bit 3 selects the address form (1) or the data form (0). Bit 2 selects subtract (1) or add (0). Bits 1:0 select the size. For data operations, 0 means byte, 1 means word and 2 means long. For address operations, 0 means word and 1 means long.

Top module: `sized_addsub_unit`

## Requirements
- R1: A byte data operation (op 0x0 add, 0x4 subtract), when enabled, replaces bits 7:0 of the destination with the 8-bit result. Bits 31:8 are copied from dst_in.
- R2: A word data operation (op 0x1 add, 0x5 subtract), when enabled, replaces bits 15:0 with the 16-bit result. Bits 31:16 are copied from dst_in.
- R3: A long data operation (op 0x2 add, 0x6 subtract), when enabled, replaces all 32 bits with the result.
- R4: After a data operation, flag_c holds the carry out of the top bit of the chosen size, or the borrow for a subtract. flag_x holds the same value as flag_c.
- R5: After a data operation, flag_n equals the top bit of the sized result. flag_z is 1 exactly when the sized result is zero.
- R6: For an add (op 0x0, 0x1 or 0x2), flag_v is set when the two sized operands share a sign and the result's sign differs from the destination's sign.
- R7: A subtract (op 0x4, 0x5 or 0x6) computes destination minus source. flag_v is set when the operand signs differ and the result's sign differs from the destination's sign.
- R8: An address word operation (op 0x8 add, 0xC subtract) sign-extends src bits 15:0 to 32 bits and applies the result to the full 32-bit destination.
- R9: An address long operation (op 0x9 add, 0xD subtract) applies the full 32-bit source to the full 32-bit destination.
- R10: Address operations (op 0x8, 0x9, 0xC, 0xD) leave all five flags unchanged.
- R11: When wr_en is 0, dst_out and all flags hold their values.
- R12: The codes 0x3, 0x7, 0xA, 0xB, 0xE and 0xF leave dst_out and all flags unchanged, even when wr_en is 1.
- R13: While rst_n is low, dst_out and all five flags are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register the result of this cycle's operation |
| op | input | 4 | Operation code: address form, subtract and size fields |
| src | input | 32 | Source operand |
| dst_in | input | 32 | Current destination register value |
| dst_out | output | 32 | Registered updated destination value |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry/borrow flag |

## Verification
The assertions assume that wr_en stays low throughout reset. They also assume that op, src and dst_in carry known values in every cycle where wr_en is high, because the stability and merge properties compare registered outputs with inputs sampled one edge earlier. The bench changes inputs only on the falling edge and keeps wr_en low until reset has been released. Its random draws cover all sixteen operation codes, including the six invalid ones, and it leaves wr_en low in about one cycle in eight.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

   localparam int OP_W = 4;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2
   } size_e;

   typedef struct packed {
      logic  valid;
      logic  addr;
      logic  sub;
      size_e size;
   } dec_t;

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
   import addsub_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output dec_t            dec
);
   logic [1:0] sel;

   assign sel = op[1:0];

   always_comb begin
      dec.addr = op[3];
      dec.sub  = op[2];
      if (op[3]) begin
         // address form: 0 word, 1 long
         dec.valid = (sel == 2'd0) || (sel == 2'd1);
         dec.size  = (sel == 2'd0) ? SZ_WORD : SZ_LONG;
      end else begin
         // data form: 0 byte, 1 word, 2 long
         dec.valid = (sel != 2'd3);
         case (sel)
            2'd0:    dec.size = SZ_BYTE;
            2'd1:    dec.size = SZ_WORD;
            default: dec.size = SZ_LONG;
         endcase
      end
   end
endmodule

// File: rtl/addsub_lane.sv
module addsub_lane #(
   parameter int DATA_W = 32,
   parameter int LW     = 8
) (
   input  logic [DATA_W-1:0] dst_in,
   input  logic [LW-1:0]     src_in,
   input  logic              sub,
   output logic [DATA_W-1:0] dst_merged,
   output logic              c,
   output logic              v,
   output logic              n,
   output logic              z
);
   logic [LW-1:0] a;
   logic [LW:0]   wide;
   logic [LW-1:0] res;
   logic          sa, sb, sr;

   assign a    = dst_in[LW-1:0];
   assign wide = sub ? ({1'b0, a} - {1'b0, src_in})
                     : ({1'b0, a} + {1'b0, src_in});
   assign res  = wide[LW-1:0];

   assign sa = a[LW-1];
   assign sb = src_in[LW-1];
   assign sr = res[LW-1];

   assign c = wide[LW];
   assign n = sr;
   assign z = (res == '0);
   assign v = sub ? ((sa ^ sb) & (sa ^ sr))
                  : (~(sa ^ sb) & (sa ^ sr));

   generate
      if (LW == DATA_W) begin : g_full
         assign dst_merged = res;
      end else begin : g_part
         assign dst_merged = {dst_in[DATA_W-1:LW], res};
      end
   endgenerate
endmodule

// File: rtl/addsub_addr.sv
module addsub_addr #(
   parameter int DATA_W = 32,
   parameter int WORD_W = 16
) (
   input  logic [DATA_W-1:0] dst_in,
   input  logic [DATA_W-1:0] src_in,
   input  logic              sub,
   input  logic              word,
   output logic [DATA_W-1:0] dst_next
);
   localparam int EXT_W = DATA_W - WORD_W;

   logic [DATA_W-1:0] ext;

   assign ext      = word ? {{EXT_W{src_in[WORD_W-1]}}, src_in[WORD_W-1:0]} : src_in;
   assign dst_next = sub ? (dst_in - ext) : (dst_in + ext);
endmodule

// File: rtl/sized_addsub_unit.sv
module sized_addsub_unit
   import addsub_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] dst_in,
   output logic [DATA_W-1:0] dst_out,
   output logic              flag_x,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_v,
   output logic              flag_c
);
   localparam int N_LANES = 3;

   generate
      if (!(BYTE_W > 0 && BYTE_W < WORD_W && WORD_W < DATA_W)) begin : g_bad_widths
         $error("sized_addsub_unit: widths must satisfy 0 < BYTE_W < WORD_W < DATA_W");
      end
   endgenerate

   dec_t dec;

   addsub_decode u_dec (
      .op  (op),
      .dec (dec)
   );

   logic [DATA_W-1:0]  lane_dst [N_LANES];
   logic [N_LANES-1:0] lane_c, lane_v, lane_n, lane_z;

   generate
      for (genvar g = 0; g < N_LANES; g++) begin : g_lane
         localparam int LW = (g == 0) ? BYTE_W : ((g == 1) ? WORD_W : DATA_W);
         addsub_lane #(
            .DATA_W (DATA_W),
            .LW     (LW)
         ) u_lane (
            .dst_in     (dst_in),
            .src_in     (src[LW-1:0]),
            .sub        (dec.sub),
            .dst_merged (lane_dst[g]),
            .c          (lane_c[g]),
            .v          (lane_v[g]),
            .n          (lane_n[g]),
            .z          (lane_z[g])
         );
      end
   endgenerate

   logic [DATA_W-1:0] addr_dst;

   addsub_addr #(
      .DATA_W (DATA_W),
      .WORD_W (WORD_W)
   ) u_addr (
      .dst_in   (dst_in),
      .src_in   (src),
      .sub      (dec.sub),
      .word     (dec.size == SZ_WORD),
      .dst_next (addr_dst)
   );

   logic [DATA_W-1:0] nxt_dst;
   logic              nxt_c, nxt_v, nxt_n, nxt_z;

   always_comb begin
      case (dec.size)
         SZ_BYTE: begin
            nxt_dst = lane_dst[0];
            nxt_c = lane_c[0]; nxt_v = lane_v[0]; nxt_n = lane_n[0]; nxt_z = lane_z[0];
         end
         SZ_WORD: begin
            nxt_dst = lane_dst[1];
            nxt_c = lane_c[1]; nxt_v = lane_v[1]; nxt_n = lane_n[1]; nxt_z = lane_z[1];
         end
         default: begin
            nxt_dst = lane_dst[2];
            nxt_c = lane_c[2]; nxt_v = lane_v[2]; nxt_n = lane_n[2]; nxt_z = lane_z[2];
         end
      endcase
      if (dec.addr) nxt_dst = addr_dst;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_out <= '0;
         flag_x  <= 1'b0;
         flag_n  <= 1'b0;
         flag_z  <= 1'b0;
         flag_v  <= 1'b0;
         flag_c  <= 1'b0;
      end else if (wr_en && dec.valid) begin
         dst_out <= nxt_dst;
         if (!dec.addr) begin
            flag_x <= nxt_c;
            flag_c <= nxt_c;
            flag_n <= nxt_n;
            flag_z <= nxt_z;
            flag_v <= nxt_v;
         end
      end
   end
endmodule

// File: rtl/sized_addsub_unit_chk.sv
module sized_addsub_unit_chk #(
   parameter int DATA_W = 32,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [3:0]        op,
   input logic [DATA_W-1:0] src,
   input logic [DATA_W-1:0] dst_in,
   input logic [DATA_W-1:0] dst_out,
   input logic              flag_x,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_v,
   input logic              flag_c
);
   logic [4:0] flags;
   logic       data_ok, addr_ok, bad_op, byte_op, word_op, long_op, addr_word;

   assign flags     = {flag_x, flag_n, flag_z, flag_v, flag_c};
   assign data_ok   = !op[3] && (op[1:0] != 2'd3);
   assign addr_ok   = op[3] && (op[1] == 1'b0);
   assign bad_op    = !data_ok && !addr_ok;
   assign byte_op   = data_ok && (op[1:0] == 2'd0);
   assign word_op   = data_ok && (op[1:0] == 2'd1);
   assign long_op   = data_ok && (op[1:0] == 2'd2);
   assign addr_word = addr_ok && (op[0] == 1'b0);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(dst_out) && $stable(flags)));

   p_bad_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bad_op) |=> ($stable(dst_out) && $stable(flags)));

   p_addr_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr_ok) |=> $stable(flags));

   p_x_mirrors_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && data_ok) |=> (flag_x == flag_c));

   p_byte_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && byte_op) |=> (dst_out[DATA_W-1:BYTE_W] == $past(dst_in[DATA_W-1:BYTE_W])));

   p_word_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && word_op) |=> (dst_out[DATA_W-1:WORD_W] == $past(dst_in[DATA_W-1:WORD_W])));

   p_byte_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && byte_op) |=> ((flag_n == dst_out[BYTE_W-1]) &&
                              (flag_z == (dst_out[BYTE_W-1:0] == '0))));

   p_long_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && long_op) |=> ((flag_n == dst_out[DATA_W-1]) &&
                              (flag_z == (dst_out == '0))));

   p_addr_word_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr_word && !op[2] && !src[WORD_W-1]) |=>
         (dst_out == $past(dst_in) + {{(DATA_W-WORD_W){1'b0}}, $past(src[WORD_W-1:0])}));
endmodule

bind sized_addsub_unit sized_addsub_unit_chk #(
   .DATA_W (DATA_W),
   .WORD_W (WORD_W),
   .BYTE_W (BYTE_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .op      (op),
   .src     (src),
   .dst_in  (dst_in),
   .dst_out (dst_out),
   .flag_x  (flag_x),
   .flag_n  (flag_n),
   .flag_z  (flag_z),
   .flag_v  (flag_v),
   .flag_c  (flag_c)
);

// File: tb/sized_addsub_unit_tb.sv
module sized_addsub_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 600;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] src = '0;
   logic [31:0] dst_in = '0;
   logic [31:0] dst_out;
   logic        flag_x, flag_n, flag_z, flag_v, flag_c;

   int          n_checks = 0;
   int          n_errors = 0;
   logic [31:0] exp_dst = '0;
   logic [4:0]  exp_f = '0;   // {x,n,z,v,c}

   always #(CLK_PERIOD/2) clk = ~clk;

   sized_addsub_unit u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op(op), .src(src), .dst_in(dst_in),
      .dst_out(dst_out), .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z),
      .flag_v(flag_v), .flag_c(flag_c)
   );

   function automatic string tag_of(input logic [3:0] o, input bit en);
      if (!en) return "R11";
      case (o)
         4'h0: return "R1/R4/R5/R6";
         4'h4: return "R1/R4/R5/R7";
         4'h1: return "R2/R4/R5/R6";
         4'h5: return "R2/R4/R5/R7";
         4'h2: return "R3/R4/R5/R6";
         4'h6: return "R3/R4/R5/R7";
         4'h8, 4'hC: return "R8/R10";
         4'h9, 4'hD: return "R9/R10";
         default: return "R12";
      endcase
   endfunction

   function automatic void model(input logic [3:0] o, input logic [31:0] s,
                                 input logic [31:0] d, input bit en);
      logic [63:0] a, b, r, mask, res, t;
      logic [31:0] ext;
      logic        c, n, z, v;
      int          w;
      if (!en) return;
      if (!o[3]) begin
         case (o[1:0])
            2'd0: w = 8;
            2'd1: w = 16;
            2'd2: w = 32;
            default: return;
         endcase
         mask = (64'd1 << w) - 64'd1;
         a = {32'd0, d} & mask;
         b = {32'd0, s} & mask;
         r = o[2] ? (a - b) : (a + b);
         c = r[w];
         res = r & mask;
         n = res[w-1];
         z = (res == 64'd0);
         t = o[2] ? ((a ^ b) & (a ^ res)) : (~(a ^ b) & (a ^ res));
         v = t[w-1];
         exp_dst = (d & ~mask[31:0]) | res[31:0];
         exp_f = {c, n, z, v, c};
      end else begin
         if (o[1]) return;
         ext = o[0] ? s : {{16{s[15]}}, s[15:0]};
         exp_dst = o[2] ? (d - ext) : (d + ext);
      end
   endfunction

   task automatic check(input string tag);
      logic [4:0] got_f;
      got_f = {flag_x, flag_n, flag_z, flag_v, flag_c};
      n_checks++;
      if (dst_out !== exp_dst || got_f !== exp_f) begin
         n_errors++;
         $display("FAIL %s: dst=%08h flags(xnzvc)=%05b expected dst=%08h flags=%05b",
                  tag, dst_out, got_f, exp_dst, exp_f);
      end
   endtask

   // called at a falling edge; checks at the next falling edge
   task automatic apply(input logic [3:0] o, input logic [31:0] s,
                        input logic [31:0] d, input bit en);
      op = o; src = s; dst_in = d; wr_en = en;
      model(o, s, d, en);
      @(negedge clk);
      check(tag_of(o, en));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R13");                                   // R13 reset state

      apply(4'h0, 32'h0000_0001, 32'hABCD_12FF, 1'b1); // R1 R4 R5: wrap to 0, C=X=1, Z=1
      apply(4'h4, 32'h0000_0001, 32'h1234_5680, 1'b1); // R7: 0x80-1 overflow
      apply(4'h0, 32'h0000_0050, 32'h0000_0050, 1'b1); // R6: byte add overflow
      apply(4'h5, 32'h0000_0001, 32'hFFFF_0000, 1'b1); // R2 R4: word borrow, N
      apply(4'h1, 32'h0000_8000, 32'h5555_8000, 1'b1); // R2 R6: word add overflow
      apply(4'h2, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1); // R3 R6: long overflow
      apply(4'h6, 32'h0000_0005, 32'h0000_0005, 1'b1); // R3 R5: zero result
      apply(4'h8, 32'h1234_8000, 32'h0000_0000, 1'b1); // R8 R10: sign-extend negative
      apply(4'hC, 32'hFFFF_0001, 32'h0001_0000, 1'b1); // R8: sub positive word
      apply(4'h9, 32'h8000_0000, 32'h8000_0000, 1'b1); // R9 R10: long wraps, flags kept
      apply(4'hD, 32'h0000_0001, 32'h0000_0000, 1'b1); // R9
      apply(4'h2, 32'h0000_0003, 32'h0000_0004, 1'b0); // R11: held
      apply(4'h3, 32'h0000_0003, 32'h0000_0004, 1'b1); // R12: invalid code
      apply(4'hF, 32'hFFFF_FFFF, 32'h0000_0004, 1'b1); // R12: invalid code

      for (int i = 0; i < N_RANDOM; i++) begin
         logic [31:0] rs, rd;
         logic [3:0]  ro;
         bit          re;
         ro = 4'($urandom_range(15));
         rs = $urandom();
         rd = $urandom();
         if ($urandom_range(3) == 0) rs = {rs[31:16], 16'h8000 ^ {15'd0, rs[0]}};
         re = ($urandom_range(7) != 0);
         apply(ro, rs, rd, re);
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule